// File: doc/BRIEF.md
# Programmable Staircase Ramp Generator

This block produces a staircase waveform for one of four DAC channels. A configuration port holds three settings: the time between steps in milliseconds, the amount added per step, and the target channel. A run command latches those settings, clears the output level to zero and starts counting millisecond ticks. Each time a full interval has elapsed, the block adds the increment to an 8-bit level and issues a one-cycle update strobe. The strobe carries the channel index and a one-hot channel select, which a downstream serial DAC driver uses to send the new value.

An interval written outside the legal window of 100 to 5000 ms is pulled to the nearer limit, and a flag reports that this happened. A stop command freezes the level and ends the strobes. Settings written while a ramp is running wait until the next run command. When a step would carry the level past the 8-bit maximum, the level returns to zero.

Top module: `stair_ramp`

## Requirements
- R1: After reset the output level is 0, the strobe and every select bit are low, the reported channel is 0, the block is not busy and the clamp flag is low.
- R2: A configuration write with an interval below 100 uses 100 and one above 5000 uses 5000, and in both cases sets `cfg_clamped` on the next cycle. A write with an interval inside 100 to 5000 uses the value as written and clears `cfg_clamped`.
- R3: Once running, the block counts only the cycles on which `ms_tick` is high. The update strobe rises in the cycle right after the clock edge that samples the tick completing an interval. The edge that accepts run does not count as a tick.
- R4: Each strobe comes with a new level, equal to the previous level plus the latched increment.
- R5: When the level plus the increment would be more than 255, the new level is 0. A sum of exactly 255 is kept.
- R6: With an increment of 0 the level stays constant, and a strobe is still issued after every interval.
- R7: After stop, no strobe is issued and the level holds its last value until the next run. If run and stop arrive together, stop wins.
- R8: A configuration write made while running changes neither the interval, the increment nor the channel of the ramp in progress. The new settings take effect at the next run.
- R9: Run clears the level to 0 and restarts interval timing from zero, even when a ramp is already running.
- R10: `upd_chan` gives the latched channel index (0 to 3). `upd_sel` is one-hot: bit n is set only during a strobe to channel n, and all bits are zero between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_interval_ms | input | 16 | Requested step interval in milliseconds |
| cfg_step | input | 8 | Increment added per step |
| cfg_chan | input | 2 | Target channel index |
| run | input | 1 | Latch settings and start the ramp from 0 |
| stop | input | 1 | Freeze the ramp |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_clamped | output | 1 | The last interval written was out of range |
| busy | output | 1 | A ramp is running |
| upd_valid | output | 1 | One-cycle update strobe |
| upd_chan | output | 2 | Channel of the current ramp |
| upd_sel | output | 4 | One-hot channel select, valid with the strobe |
| upd_level | output | 8 | Current ramp level |

## Verification
The main ramp is driven from a table of settings. The table covers an interval below the window, one above it, the two exact limits, an odd in-range value, increments of 0x00, 0x10, 0x55, 0x80 and 0xFF, and every channel. These separate the clamp path from the in-range path. They also separate a wrap caused by a real carry from a level that reaches exactly 255, and a constant ramp from a stalled timer. Separate directed runs check three more patterns:
- Sparse ticks show that only tick cycles count toward the interval.
- A mid-run configuration write shows that the running ramp keeps its latched settings until the next run.
- A stop followed by a long wait shows that the level is frozen and no strobe appears.

// File: rtl/stair_pkg.sv
package stair_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } stair_state_e;

   localparam int unsigned DEF_MIN_MS = 100;
   localparam int unsigned DEF_MAX_MS = 5000;
   localparam int unsigned DEF_LVL_W  = 8;
   localparam int unsigned DEF_CHAN_N = 4;
   localparam int unsigned DEF_IN_W   = 16;

endpackage

// File: rtl/stair_cfg.sv
module stair_cfg #(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned LVL_W  = 8,
   parameter int unsigned CH_W   = 2,
   parameter int unsigned MIN_MS = 100,
   parameter int unsigned MAX_MS = 5000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IN_W-1:0]  interval_in,
   input  logic [LVL_W-1:0] incr_in,
   input  logic [CH_W-1:0]  chan_in,
   output logic [CNT_W-1:0] interval_o,
   output logic [LVL_W-1:0] incr_o,
   output logic [CH_W-1:0]  chan_o,
   output logic             clamp_o
);

   localparam logic [IN_W-1:0]  LO_IN  = IN_W'(MIN_MS);
   localparam logic [IN_W-1:0]  HI_IN  = IN_W'(MAX_MS);
   localparam logic [CNT_W-1:0] LO_CNT = CNT_W'(MIN_MS);
   localparam logic [CNT_W-1:0] HI_CNT = CNT_W'(MAX_MS);

   logic             below, above;
   logic [CNT_W-1:0] legal;

   always_comb begin
      below = interval_in < LO_IN;
      above = interval_in > HI_IN;
      if (below)      legal = LO_CNT;
      else if (above) legal = HI_CNT;
      else            legal = interval_in[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         interval_o <= LO_CNT;
         incr_o     <= LVL_W'(1);
         chan_o     <= '0;
         clamp_o    <= 1'b0;
      end else if (we) begin
         interval_o <= legal;
         incr_o     <= incr_in;
         chan_o     <= chan_in;
         clamp_o    <= below | above;
      end
   end

   p_interval_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (interval_o >= LO_CNT) && (interval_o <= HI_CNT));

   p_clamp_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (interval_in < LO_IN)) |=> (clamp_o && (interval_o == LO_CNT)));

   p_clamp_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (interval_in > HI_IN)) |=> (clamp_o && (interval_o == HI_CNT)));

endmodule

// File: rtl/stair_interval.sv
module stair_interval
   import stair_pkg::*;
#(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             halt,
   input  logic             tick,
   input  logic [CNT_W-1:0] interval_i,
   output logic             fire_o,
   output logic             strobe_o,
   output logic             running_o
);

   stair_state_e     state;
   logic [CNT_W-1:0] span_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last      = (cnt_q == (span_q - CNT_W'(1)));
   assign running_o = (state == ST_RUN);
   assign fire_o    = running_o & tick & ~start & ~halt & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         span_q <= CNT_W'(DEF_MIN_MS);
         cnt_q  <= '0;
      end else if (start) begin
         state  <= ST_RUN;
         span_q <= interval_i;
         cnt_q  <= '0;
      end else if (halt) begin
         state  <= ST_IDLE;
         cnt_q  <= '0;
      end else if (running_o && tick) begin
         cnt_q  <= last ? '0 : cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_o <= 1'b0;
      else        strobe_o <= fire_o;
   end

   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      running_o |-> (cnt_q < span_q));

   p_strobe_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> ($past(running_o) && $past(tick) && !$past(halt)));

   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (running_o && (cnt_q == '0) && !strobe_o));

endmodule

// File: rtl/stair_level.sv
module stair_level #(
   parameter int unsigned LVL_W  = 8,
   parameter int unsigned CHAN_N = 4,
   parameter int unsigned CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fire,
   input  logic              strobe,
   input  logic [LVL_W-1:0]  incr_i,
   input  logic [CH_W-1:0]   chan_i,
   output logic [LVL_W-1:0]  level_o,
   output logic [CH_W-1:0]   chan_o,
   output logic [CHAN_N-1:0] sel_o
);

   logic [LVL_W-1:0] inc_q;
   logic [LVL_W:0]   sum;
   logic [LVL_W-1:0] nxt;

   assign sum = {1'b0, level_o} + {1'b0, inc_q};
   assign nxt = sum[LVL_W] ? '0 : sum[LVL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= '0;
         inc_q   <= '0;
         chan_o  <= '0;
      end else if (start) begin
         level_o <= '0;
         inc_q   <= incr_i;
         chan_o  <= chan_i;
      end else if (fire) begin
         level_o <= nxt;
      end
   end

   for (genvar g = 0; g < CHAN_N; g++) begin : g_sel
      assign sel_o[g] = strobe && (chan_o == CH_W'(g));
   end

   p_start_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (level_o == '0));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !fire) |=> $stable(level_o));

   p_step_nodrop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !start && !sum[LVL_W]) |=> (level_o >= $past(level_o)));

endmodule

// File: rtl/stair_ramp.sv
module stair_ramp
   import stair_pkg::*;
#(
   parameter int unsigned IN_W   = DEF_IN_W,
   parameter int unsigned LVL_W  = DEF_LVL_W,
   parameter int unsigned CHAN_N = DEF_CHAN_N,
   parameter int unsigned MIN_MS = DEF_MIN_MS,
   parameter int unsigned MAX_MS = DEF_MAX_MS,
   localparam int unsigned CH_W  = $clog2(CHAN_N),
   localparam int unsigned CNT_W = $clog2(MAX_MS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IN_W-1:0]   cfg_interval_ms,
   input  logic [LVL_W-1:0]  cfg_step,
   input  logic [CH_W-1:0]   cfg_chan,
   input  logic              run,
   input  logic              stop,
   input  logic              ms_tick,
   output logic              cfg_clamped,
   output logic              busy,
   output logic              upd_valid,
   output logic [CH_W-1:0]   upd_chan,
   output logic [CHAN_N-1:0] upd_sel,
   output logic [LVL_W-1:0]  upd_level
);

   if (CHAN_N < 2) begin : g_bad_chan
      $error("stair_ramp: CHAN_N must be at least 2");
   end
   if (MIN_MS < 1 || MIN_MS > MAX_MS) begin : g_bad_range
      $error("stair_ramp: need 1 <= MIN_MS <= MAX_MS");
   end
   if (IN_W < CNT_W) begin : g_bad_inw
      $error("stair_ramp: IN_W narrower than interval counter");
   end
   if (LVL_W < 2) begin : g_bad_lvl
      $error("stair_ramp: LVL_W too small");
   end

   logic [CNT_W-1:0] cur_interval;
   logic [LVL_W-1:0] cur_incr;
   logic [CH_W-1:0]  cur_chan;
   logic             start, fire;

   assign start = run & ~stop;

   stair_cfg #(
      .IN_W  (IN_W),
      .CNT_W (CNT_W),
      .LVL_W (LVL_W),
      .CH_W  (CH_W),
      .MIN_MS(MIN_MS),
      .MAX_MS(MAX_MS)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .interval_in(cfg_interval_ms),
      .incr_in    (cfg_step),
      .chan_in    (cfg_chan),
      .interval_o (cur_interval),
      .incr_o     (cur_incr),
      .chan_o     (cur_chan),
      .clamp_o    (cfg_clamped)
   );

   stair_interval #(
      .CNT_W(CNT_W)
   ) u_interval (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .halt      (stop),
      .tick      (ms_tick),
      .interval_i(cur_interval),
      .fire_o    (fire),
      .strobe_o  (upd_valid),
      .running_o (busy)
   );

   stair_level #(
      .LVL_W (LVL_W),
      .CHAN_N(CHAN_N),
      .CH_W  (CH_W)
   ) u_level (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .fire   (fire),
      .strobe (upd_valid),
      .incr_i (cur_incr),
      .chan_i (cur_chan),
      .level_o(upd_level),
      .chan_o (upd_chan),
      .sel_o  (upd_sel)
   );

   p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_sel));

   p_sel_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((upd_sel != '0) == upd_valid));

   p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!busy && !upd_valid));

endmodule

// File: tb/stair_ramp_tb.sv
`timescale 1ns/1ps
module stair_ramp_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_interval_ms = '0;
   logic [7:0]  cfg_step = '0;
   logic [1:0]  cfg_chan = '0;
   logic        run = 1'b0;
   logic        stop = 1'b0;
   logic        ms_tick = 1'b0;
   logic        cfg_clamped, busy, upd_valid;
   logic [1:0]  upd_chan;
   logic [3:0]  upd_sel;
   logic [7:0]  upd_level;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   stair_ramp u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_interval_ms(cfg_interval_ms),
      .cfg_step(cfg_step), .cfg_chan(cfg_chan), .run(run), .stop(stop),
      .ms_tick(ms_tick), .cfg_clamped(cfg_clamped), .busy(busy),
      .upd_valid(upd_valid), .upd_chan(upd_chan), .upd_sel(upd_sel),
      .upd_level(upd_level)
   );

   typedef struct packed {
      logic [15:0] ivl;
      logic [7:0]  inc;
      logic [1:0]  ch;
      logic [3:0]  steps;
      logic [12:0] exp_ivl;
      logic        exp_clamp;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{16'd100,  8'h10, 2'd0, 4'd3, 13'd100,  1'b0},
      '{16'd40,   8'h55, 2'd1, 4'd4, 13'd100,  1'b1},
      '{16'd6000, 8'h80, 2'd2, 4'd3, 13'd5000, 1'b1},
      '{16'd250,  8'h00, 2'd3, 4'd2, 13'd250,  1'b0},
      '{16'd101,  8'hFF, 2'd3, 4'd2, 13'd101,  1'b0},
      '{16'd5000, 8'h01, 2'd1, 4'd1, 13'd5000, 1'b0},
      '{16'd99,   8'h03, 2'd0, 4'd1, 13'd100,  1'b1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [15:0] ivl, input logic [7:0] inc, input logic [1:0] ch);
      @(negedge clk);
      cfg_we = 1'b1; cfg_interval_ms = ivl; cfg_step = inc; cfg_chan = ch;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic do_run();
      @(negedge clk);
      run = 1'b1;
      @(posedge clk); #1;
      run = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk);
      stop = 1'b1;
      @(posedge clk); #1;
      stop = 1'b0;
   endtask

   task automatic wait_strobe(output int n);
      n = 0;
      do begin
         @(posedge clk); #1;
         n++;
         if (!upd_valid) chk(upd_sel == 4'd0, "R10 idle select", upd_sel, 0);
      end while (!upd_valid && n < 6000);
   endtask

   initial begin : watchdog
      #(4 * 190000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int n;
      int lvl;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(upd_level == 8'd0, "R1 level", upd_level, 0);
      chk(!upd_valid && upd_sel == 4'd0, "R1 strobe", upd_sel, 0);
      chk(!busy && !cfg_clamped && upd_chan == 2'd0, "R1 flags", busy, 0);
      @(negedge clk) rst_n = 1'b1;
      ms_tick = 1'b1;

      // table walk: R2 R3 R4 R5 R6 R10
      for (int v = 0; v < NV; v++) begin
         write_cfg(VECS[v].ivl, VECS[v].inc, VECS[v].ch);
         chk(cfg_clamped == VECS[v].exp_clamp, "R2 clamp flag", cfg_clamped, VECS[v].exp_clamp);
         do_run();
         chk(upd_level == 8'd0 && busy, "R9 start level", upd_level, 0);
         lvl = 0;
         for (int s = 0; s < int'(VECS[v].steps); s++) begin
            wait_strobe(n);
            lvl = (lvl + int'(VECS[v].inc) > 255) ? 0 : lvl + int'(VECS[v].inc);
            chk(n == int'(VECS[v].exp_ivl), "R3 interval", n, VECS[v].exp_ivl);
            chk(upd_level == lvl[7:0], "R4/R5/R6 level", upd_level, lvl);
            chk(upd_chan == VECS[v].ch, "R10 chan", upd_chan, VECS[v].ch);
            chk(upd_sel == (4'd1 << VECS[v].ch), "R10 sel", upd_sel, 1 << VECS[v].ch);
         end
         do_stop();
      end

      // R7 stop freezes level and strobes
      write_cfg(16'd100, 8'd5, 2'd2);
      do_run();
      wait_strobe(n);
      chk(upd_level == 8'd5, "R7 pre-stop level", upd_level, 5);
      do_stop();
      n = 0;
      for (int i = 0; i < 300; i++) begin
         @(posedge clk); #1;
         if (upd_valid) n++;
      end
      chk(n == 0, "R7 strobes after stop", n, 0);
      chk(upd_level == 8'd5 && !busy, "R7 frozen level", upd_level, 5);

      // R7 run and stop together: stop wins
      @(negedge clk); run = 1'b1; stop = 1'b1;
      @(posedge clk); #1; run = 1'b0; stop = 1'b0;
      chk(!busy && upd_level == 8'd5, "R7 stop beats run", busy, 0);

      // R3 only tick cycles count
      ms_tick = 1'b0;
      write_cfg(16'd100, 8'd7, 2'd1);
      do_run();
      n = 0;
      for (int i = 0; i < 400; i++) begin
         @(posedge clk); #1;
         if (upd_valid) n++;
      end
      chk(n == 0, "R3 no tick no strobe", n, 0);
      n = 0;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         ms_tick = (i % 2 == 0);
         if (ms_tick) n++;
         @(posedge clk); #1;
         if (upd_valid) break;
      end
      chk(upd_valid && n == 100, "R3 sparse tick count", n, 100);
      chk(upd_level == 8'd7, "R4 sparse level", upd_level, 7);
      @(negedge clk) ms_tick = 1'b1;
      do_stop();

      // R8 mid-run config write, R9 rerun applies it
      write_cfg(16'd100, 8'd10, 2'd0);
      do_run();
      repeat (29) @(posedge clk);
      #1;
      write_cfg(16'd200, 8'd50, 2'd3);
      wait_strobe(n);
      chk(n == 70, "R8 interval unchanged", n, 70);
      chk(upd_level == 8'd10 && upd_chan == 2'd0, "R8 incr/chan unchanged", upd_level, 10);
      do_run();
      chk(upd_level == 8'd0, "R9 rerun clears level", upd_level, 0);
      wait_strobe(n);
      chk(n == 200, "R9 new interval", n, 200);
      chk(upd_level == 8'd50 && upd_chan == 2'd3, "R9 new incr/chan", upd_level, 50);
      do_stop();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule